// File: doc/BRIEF.md
# Byte-Request Serial Receive Port

This block sits on the receiving end of a byte-oriented serial link whose far side is a framer device. It produces the serial bit enable (`sclkTick`) that paces both sides, marks the start of every frame with a one-cycle frame strobe, and asks for bytes with a data-request line. The framer answers a request with a one-tick byte strobe that comes together with the most significant bit. The remaining seven bits follow on the next seven ticks, and the port hands the assembled byte to the parallel side as a one-cycle valid pulse with data.

Every serial action happens on a "tick edge", which is a rising `clk` edge at which `sclkTick` is high. The framer drives its strobe and data between tick edges. The port decides again in the middle of each byte whether it wants the next one, at the tick edge that captures bit 1. The framer therefore sees the answer while it is still sending bit 0, and consecutive bytes can run with no idle tick between them. A host-set byte limit caps how many bytes are requested in each frame. A host-driven not-ready input keeps the request from being raised.

Top module: `srx_port`

## Requirements
- R1: A synchronous active-low reset (`rstN` low at a rising edge) forces `dataReq`, `byteValid` and `frameStrobe` low.
- R2: `sclkTick` is high for one `clk` cycle in every `TICK_DIV` cycles. `dataReq` changes only at tick edges.
- R3: `frameStrobe` pulses for one cycle every `FRAME_TICKS` ticks (`TICK_DIV*FRAME_TICKS` cycles apart). `dataReq` stays low until the first frame strobe has occurred.
- R4: While idle, the port raises `dataReq` at the first tick edge at which the first frame has started, `byteReadyN` is low and the frame's byte count is below `byteLimit`. After a frame strobe this makes `dataReq` visible `TICK_DIV` cycles after the `frameStrobe` cycle.
- R5: Once raised, `dataReq` stays high until a strobe arrives, and `byteStrobe` is sampled on every tick edge while the port waits.
- R6: A tick edge with `dataReq` high and `byteStrobe` high captures bit 7 from `serData`. The next seven tick edges capture bits 6 to 0, MSB first. The byte then appears on `byteData` with `byteValid` high for exactly one cycle; `byteData[7]` holds the first bit received.
- R7: At the tick edge that captures bit 1, `dataReq` is set high only if `byteReadyN` is low and (count + 1) < `byteLimit`. If it is high, a strobe at the tick edge right after bit 0 starts the next byte, so consecutive strobes are exactly 8 ticks apart.
- R8: Once a byte has started, all 8 bits are received and the byte is delivered, whatever `dataReq` or `byteReadyN` do during it.
- R9: The per-frame byte count clears at every frame edge, and clearing wins over a byte that completes on the same edge. No more than `byteLimit` bytes are requested per frame; a limit of 0 requests none.
- R10: While `byteReadyN` is high, `dataReq` is never raised. A `byteStrobe` seen while no request is outstanding is ignored and delivers no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Synchronous reset, active low |
| byteLimit | input | CNT_W | Bytes to request per frame (host setting) |
| byteReadyN | input | 1 | High blocks raising a new request |
| byteStrobe | input | 1 | One-tick strobe from the framer marking bit 7 |
| serData | input | 1 | Serial data from the framer, MSB first |
| sclkTick | output | 1 | Serial bit enable shared with the framer |
| frameStrobe | output | 1 | One-cycle frame start marker |
| dataReq | output | 1 | Request for the next byte |
| byteValid | output | 1 | One-cycle flag for a completed byte |
| byteData | output | 8 | Completed byte |

## Verification
A byte can finish on the same tick edge at which a new frame begins and clears the byte count. The bench provokes this with a byte limit of 8 and a seven-tick stall before the first strobe, which makes the seventh gapless byte end exactly on the frame edge. The result is judged from the following frame: if the clear takes priority, the stream continues and 7 bytes land inside that frame, while a count carried over stops the stream after a single byte.

// File: rtl/srxPkg.sv
package srxPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SHIFT
  } srxState_t;

  typedef struct packed {
    logic capture;
    logic finish;
    logic clearCount;
  } srxStrobes_t;

endpackage

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import srxPkg::*;
#(
  parameter int TICK_DIV    = 2,
  parameter int FRAME_TICKS = 64,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] byteLimit,
  input  logic [CNT_W-1:0] byteCount,
  input  logic             byteReadyN,
  input  logic             byteStrobe,
  output logic             sclkTick,
  output logic             frameStrobe,
  output logic             dataReq,
  output srxStrobes_t      strobes
);

  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int FRM_W = (FRAME_TICKS > 1) ? $clog2(FRAME_TICKS) : 1;
  localparam logic [CNT_W:0] ONE = 1;

  logic [DIV_W-1:0] divCnt;
  logic [FRM_W-1:0] frameCnt;
  logic             frameActive;
  srxState_t        state;
  logic [2:0]       bitsLeft;
  logic             frameEdge;
  logic             roomNow;
  logic             roomNext;
  logic             wantNext;

  assign sclkTick  = (divCnt == DIV_W'(TICK_DIV - 1));
  assign frameEdge = sclkTick && (frameCnt == FRM_W'(FRAME_TICKS - 1));
  assign roomNow   = {1'b0, byteCount} < {1'b0, byteLimit};
  assign roomNext  = ({1'b0, byteCount} + ONE) < {1'b0, byteLimit};
  assign wantNext  = !byteReadyN && roomNext;

  always_comb begin
    strobes            = '0;
    strobes.capture    = sclkTick && ((state == ST_WAIT && byteStrobe) || state == ST_SHIFT);
    strobes.finish     = sclkTick && (state == ST_SHIFT) && (bitsLeft == 3'd0);
    strobes.clearCount = frameEdge;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt      <= '0;
      frameCnt    <= '0;
      frameActive <= 1'b0;
      frameStrobe <= 1'b0;
      state       <= ST_IDLE;
      bitsLeft    <= '0;
      dataReq     <= 1'b0;
    end else begin
      frameStrobe <= frameEdge;
      divCnt      <= sclkTick ? '0 : divCnt + 1'b1;
      if (sclkTick) frameCnt <= frameEdge ? '0 : frameCnt + 1'b1;
      if (frameEdge) frameActive <= 1'b1;
      if (sclkTick) begin
        case (state)
          ST_IDLE: begin
            if (frameActive && !byteReadyN && roomNow) begin
              dataReq <= 1'b1;
              state   <= ST_WAIT;
            end
          end
          ST_WAIT: begin
            if (byteStrobe) begin
              state    <= ST_SHIFT;
              bitsLeft <= 3'd6;
            end
          end
          ST_SHIFT: begin
            if (bitsLeft == 3'd1) dataReq <= wantNext;
            if (bitsLeft == 3'd0) state <= dataReq ? ST_WAIT : ST_IDLE;
            else bitsLeft <= bitsLeft - 3'd1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/srx_datapath.sv
module srx_datapath
  import srxPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  srxStrobes_t      strobes,
  input  logic             serData,
  output logic             byteValid,
  output logic [7:0]       byteData,
  output logic [CNT_W-1:0] byteCount
);

  logic [6:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      byteValid <= 1'b0;
      byteData  <= '0;
      byteCount <= '0;
    end else begin
      byteValid <= strobes.finish;
      if (strobes.capture) shiftReg <= {shiftReg[5:0], serData};
      if (strobes.finish) byteData <= {shiftReg, serData};
      // a frame edge wins over a byte finishing on the same tick
      if (strobes.clearCount) byteCount <= '0;
      else if (strobes.finish) byteCount <= byteCount + 1'b1;
    end
  end

endmodule

// File: rtl/srx_port.sv
module srx_port
  import srxPkg::*;
#(
  parameter int TICK_DIV    = 2,
  parameter int FRAME_TICKS = 64,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] byteLimit,
  input  logic             byteReadyN,
  input  logic             byteStrobe,
  input  logic             serData,
  output logic             sclkTick,
  output logic             frameStrobe,
  output logic             dataReq,
  output logic             byteValid,
  output logic [7:0]       byteData
);

  srxStrobes_t      strobes;
  logic [CNT_W-1:0] byteCount;

  srx_ctrl #(
    .TICK_DIV   (TICK_DIV),
    .FRAME_TICKS(FRAME_TICKS),
    .CNT_W      (CNT_W)
  ) ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .byteLimit  (byteLimit),
    .byteCount  (byteCount),
    .byteReadyN (byteReadyN),
    .byteStrobe (byteStrobe),
    .sclkTick   (sclkTick),
    .frameStrobe(frameStrobe),
    .dataReq    (dataReq),
    .strobes    (strobes)
  );

  srx_datapath #(
    .CNT_W(CNT_W)
  ) dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .serData  (serData),
    .byteValid(byteValid),
    .byteData (byteData),
    .byteCount(byteCount)
  );

endmodule

// File: rtl/srx_checker.sv
module srx_checker (
  input logic clk,
  input logic rstN,
  input logic byteReadyN,
  input logic sclkTick,
  input logic frameStrobe,
  input logic dataReq,
  input logic byteValid
);

  logic seenFrame;

  always_ff @(posedge clk) begin
    if (!rstN) seenFrame <= 1'b0;
    else if (frameStrobe) seenFrame <= 1'b1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |=> (!dataReq && !byteValid && !frameStrobe));

  assert_req_on_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(sclkTick) |-> $stable(dataReq));

  assert_frame_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe |=> !frameStrobe);

  assert_no_early_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    !seenFrame |-> !dataReq);

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);

  assert_ready_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataReq) |-> !$past(byteReadyN));

endmodule

bind srx_port srx_checker chk (
  .clk        (clk),
  .rstN       (rstN),
  .byteReadyN (byteReadyN),
  .sclkTick   (sclkTick),
  .frameStrobe(frameStrobe),
  .dataReq    (dataReq),
  .byteValid  (byteValid)
);

// File: tb/srx_port_test.sv
module srx_port_test;

  localparam int TICK_DIV    = 2;
  localparam int FRAME_TICKS = 64;
  localparam int CNT_W       = 8;
  localparam int FRAME_CYC   = TICK_DIV * FRAME_TICKS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CNT_W-1:0] byteLimit = '0;
  logic byteReadyN = 1'b1;
  logic byteStrobe = 1'b0;
  logic serData = 1'b0;
  logic sclkTick, frameStrobe, dataReq, byteValid;
  logic [7:0] byteData;

  always #5 clk = ~clk;

  srx_port #(.TICK_DIV(TICK_DIV), .FRAME_TICKS(FRAME_TICKS), .CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .byteLimit(byteLimit), .byteReadyN(byteReadyN),
    .byteStrobe(byteStrobe), .serData(serData), .sclkTick(sclkTick),
    .frameStrobe(frameStrobe), .dataReq(dataReq), .byteValid(byteValid),
    .byteData(byteData)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // framer model: acts on negedges that precede a tick edge
  bit busy = 0;
  int bitIdx = 0;
  logic [7:0] curByte = '0;
  int stallLeft = 0;
  bit strayMode = 0;
  int tickNum = 0;
  int prevStrobeTick = 0;
  bit prevValid = 0;
  int gapErrs = 0;
  int sentCnt = 0;
  logic [7:0] sentQ [256];

  always @(negedge clk) begin
    if (!rstN) begin
      busy = 0;
      byteStrobe = 0;
      serData = 0;
    end else if (sclkTick) begin
      tickNum++;
      if (busy) begin
        bitIdx--;
        byteStrobe = 0;
        serData = curByte[bitIdx];
        if (bitIdx == 0) busy = 0;
      end else if (dataReq && stallLeft > 0) begin
        stallLeft--;
        byteStrobe = 0;
      end else if (dataReq) begin
        curByte = 8'h3C + 8'(sentCnt * 29);
        sentQ[sentCnt % 256] = curByte;
        sentCnt++;
        busy = 1;
        bitIdx = 7;
        byteStrobe = 1;
        serData = curByte[7];
        if (prevValid && (tickNum - prevStrobeTick) != 8) gapErrs++;
        prevStrobeTick = tickNum;
        prevValid = 1;
      end else if (strayMode) begin
        byteStrobe = 1;
        serData = 1;
      end else begin
        byteStrobe = 0;
      end
    end
  end

  // receive monitor
  int frameRx = 0;
  int boundaryHits = 0;
  int rcvCnt = 0;
  int dataErr = 0;
  int earlyReq = 0;
  bit seenFrame = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (frameStrobe) begin
        frameRx = 0;
        seenFrame = 1;
      end
      if (!seenFrame && dataReq) earlyReq++;
      if (byteValid) begin
        if (byteData !== sentQ[rcvCnt % 256]) dataErr++;
        rcvCnt++;
        if (frameStrobe) boundaryHits++;
        else frameRx++;
      end
    end
  end

  task automatic waitFrame();
    @(negedge clk);
    while (!frameStrobe) @(negedge clk);
  endtask

  task automatic startScenario(input int limit, input int stall);
    byteReadyN = 1;
    waitFrame();
    waitFrame();
    byteLimit = CNT_W'(limit);
    byteReadyN = 0;
    stallLeft = stall;
    prevValid = 0;
    gapErrs = 0;
  endtask

  task automatic testReset();
    repeat (4) @(negedge clk);
    check("R1 dataReq in reset", int'(dataReq), 0);
    check("R1 byteValid in reset", int'(byteValid), 0);
    check("R1 frameStrobe in reset", int'(frameStrobe), 0);
    @(negedge clk);
    rstN = 1;
  endtask

  task automatic testTickAndFrame();
    int n;
    byteLimit = 3;
    byteReadyN = 0;
    @(negedge clk);
    while (!sclkTick) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (!sclkTick);
    check("R2 tick spacing", n, TICK_DIV);
    waitFrame();
    check("R3 requests before first frame", earlyReq, 0);
    n = 0;
    do begin @(negedge clk); n++; end while (!frameStrobe);
    check("R3 frame spacing", n, FRAME_CYC);
  endtask

  task automatic testBasic();
    int n;
    startScenario(3, 0);
    n = 0;
    while (!dataReq) begin @(negedge clk); n++; end
    check("R4 request latency after frame", n, TICK_DIV);
    repeat (FRAME_CYC - 1 - n) @(negedge clk);
    check("R9 bytes with limit 3", frameRx, 3);
    check("R7 gapless strobes", gapErrs, 0);
    check("R6 byte values", dataErr, 0);
  endtask

  task automatic testStall();
    int lows;
    startScenario(2, 5);
    repeat (2) @(negedge clk);
    lows = 0;
    for (int i = 0; i < 10; i++) begin
      if (!dataReq) lows++;
      @(negedge clk);
    end
    check("R5 request held during stall", lows, 0);
    repeat (FRAME_CYC - 13) @(negedge clk);
    check("R5 bytes after stall", frameRx, 2);
    check("R7 gapless after stall", gapErrs, 0);
  endtask

  task automatic testNotReady();
    int highs;
    byteReadyN = 1;
    waitFrame();
    waitFrame();
    byteLimit = 5;
    strayMode = 1;
    highs = 0;
    for (int i = 0; i < FRAME_CYC - 1; i++) begin
      @(negedge clk);
      if (dataReq) highs++;
    end
    strayMode = 0;
    check("R10 no request while not ready", highs, 0);
    check("R10 stray strobes give no byte", frameRx, 0);
  endtask

  task automatic testZeroLimit();
    int highs;
    startScenario(0, 0);
    highs = 0;
    for (int i = 0; i < FRAME_CYC - 1; i++) begin
      @(negedge clk);
      if (dataReq) highs++;
    end
    check("R9 no request with limit 0", highs, 0);
    check("R9 no bytes with limit 0", frameRx, 0);
  endtask

  task automatic testDropMidByte();
    int s0;
    int n;
    startScenario(4, 0);
    s0 = sentCnt;
    n = 0;
    while (!(sentCnt == s0 + 2 && busy && bitIdx <= 5)) begin
      @(negedge clk);
      n++;
    end
    byteReadyN = 1;
    repeat (FRAME_CYC - 1 - n) @(negedge clk);
    check("R8 started byte completes, R7 no further request", frameRx, 2);
  endtask

  task automatic testFrameBoundary();
    int b0;
    startScenario(8, 7);
    repeat (FRAME_CYC - 1) @(negedge clk);
    check("R9 bytes before aligned edge", frameRx, 6);
    b0 = boundaryHits;
    repeat (FRAME_CYC) @(negedge clk);
    check("R9 byte completing on frame edge", boundaryHits - b0, 1);
    check("R9 count clear wins at frame edge", frameRx, 7);
    check("R6 all byte values", dataErr, 0);
    check("R7 gapless across frame edge", gapErrs, 0);
  endtask

  initial begin
    testReset();
    testTickAndFrame();
    testBasic();
    testStall();
    testNotReady();
    testZeroLimit();
    testDropMidByte();
    testFrameBoundary();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule